// File: doc/BRIEF.md
# Oscillator Prescaler, Machine-Cycle Sequencer and Power-Mode Controller

This block takes the raw oscillator of a small 8-bit controller and turns it into the enables that clock the rest of the chip. Nothing downstream sees a derived clock. Every flop runs on the oscillator and advances only when its enable is high.

An optional divide-by-two stage sets the internal tick rate. A six-phase sequencer splits the ticks into machine cycles. A reset qualifier accepts the reset pin only after it has been held long enough. The ports are pushed high as soon as the pin rises.

Software can ask for two low-power states. Idle stops the CPU enable and leaves the peripheral enable running; an enabled interrupt or a hardware reset ends it. Power-down freezes every enable, and only the reset pin releases it. On that release the internal reset is stretched so that the oscillator can settle.

The block has no data stream, so there is no valid/ready interface. All pins are plain level or pulse controls, sampled on the rising oscillator edge. The reset pin is assumed to be synchronous to the oscillator.

Top module: `clk_pwr_ctrl`

## Requirements
- R1: With the divider in use (`x2_sel` low when last captured), `periph_ce` is high on exactly one of every two oscillator cycles.
- R2: With the divider bypassed (`x2_sel` high when last captured), `periph_ce` is high on every oscillator cycle while the block is running.
- R3: `mc_phase` advances by one on each internal tick, counting 0,1,2,3,4,5 and then back to 0. `mc_strobe` is high only on a tick taken in phase 5, so 12 ticks that start from phase 0 give exactly 2 strobes.
- R4: `core_rst` rises only once the reset pin has been seen high on 12 internal ticks in a row (two machine cycles). A shorter high pulse has no effect. `core_rst` falls one oscillator edge after the pin goes low.
- R5: `port_hi` is high in the same cycle that the reset pin is high, before any clock edge has sampled the pin.
- R6: `x2_sel` is captured only on edges where the reset pin is high. A change while the pin is low leaves the tick rate unchanged.
- R7: An idle request takes effect at the end of the current machine cycle. After that, `cpu_ce` stays low while `periph_ce` keeps ticking.
- R8: Idle ends on the first edge where some bit of `wake_irq` is high and the same bit of `irq_en` is high. A wake bit whose enable is low is ignored.
- R9: In power-down, `periph_ce` and `cpu_ce` stay low and wake inputs are ignored. Only the reset pin ends it.
- R10: When idle and power-down are requested together, power-down wins.
- R11: The edge that leaves power-down raises `core_rst` and holds it for SETTLE_CYC (default 16) oscillator cycles, even if the reset pin drops at once.
- R12: While `core_rst` is high, `mc_phase` is held at 0 and idle and power-down requests are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Raw oscillator clock; every flop runs on its rising edge |
| rst_pin | input | 1 | Hardware reset pin, active high |
| x2_sel | input | 1 | 1 bypasses the divide-by-two stage; captured only during reset |
| idle_req | input | 1 | Software request for idle, one-cycle pulse |
| pdown_req | input | 1 | Software request for power-down, one-cycle pulse |
| wake_irq | input | N_IRQ | Interrupt lines able to end idle |
| irq_en | input | N_IRQ | Per-line enable for wake_irq |
| cpu_ce | output | 1 | CPU clock enable |
| periph_ce | output | 1 | Peripheral clock enable (internal tick) |
| mc_phase | output | $clog2(MC_LEN) | Current phase within the machine cycle |
| mc_strobe | output | 1 | High on the tick that closes a machine cycle |
| core_rst | output | 1 | Qualified and stretched internal reset |
| port_hi | output | 1 | Forces all port pins high |

## Verification
The bench counts ticks against the reset pin to find the exact edge where qualification completes. A qualifier that counts oscillator cycles instead of ticks, or that is off by one, moves `core_rst` to the wrong cycle. A glitch shorter than two machine cycles must leave `core_rst` low.

An idle request is placed mid-cycle, and `cpu_ce` is checked on the phase-5 tick and on the tick after it. A controller that acts on the request at once stops the CPU too early. A wake bit is then raised with its enable low, and a controller that ignores the mask leaves idle by mistake.

Idle and power-down are requested together, and `periph_ce` is then watched. Choosing idle would leave it ticking.

The reset pin is pulsed for one cycle to leave power-down. `core_rst` must then last exactly the settle count. A request arriving inside that window must not send the core back to idle.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_IDLE  = 2'd1,
    PM_PDOWN = 2'd2
  } pmode_t;
endpackage

// File: rtl/cpc_prescaler.sv
module cpc_prescaler (
  input  logic osc_clk,
  input  logic rst_pin,
  input  logic x2_sel,
  input  logic run_en,
  output logic tick
);
  logic x2_q;
  logic div_q;

  // The rate select is latched only while the pin holds the chip in reset.
  always_ff @(posedge osc_clk) begin
    if (rst_pin) x2_q <= x2_sel;
  end

  // Divide-by-two toggle; parked low while all clocks are stopped.
  always_ff @(posedge osc_clk) begin
    div_q <= run_en ? !div_q : 1'b0;
  end

  assign tick = run_en & (x2_q | div_q);

  // R1
  div_alt_chk: assert property (@(posedge osc_clk) disable iff (rst_pin)
    (!x2_q && tick) |=> !tick);

  // R6
  x2_hold_chk: assert property (@(posedge osc_clk) disable iff (rst_pin)
    !rst_pin |=> $stable(x2_q));
endmodule

// File: rtl/cpc_mc_seq.sv
module cpc_mc_seq #(
  parameter int MC_LEN = 6
) (
  input  logic                      osc_clk,
  input  logic                      tick,
  input  logic                      hold,
  output logic [$clog2(MC_LEN)-1:0] phase,
  output logic                      mc_end
);
  localparam int PW = $clog2(MC_LEN);
  localparam logic [PW-1:0] LAST = PW'(MC_LEN - 1);

  always_ff @(posedge osc_clk) begin
    if (hold)      phase <= '0;
    else if (tick) phase <= (phase == LAST) ? '0 : phase + 1'b1;
  end

  assign mc_end = tick & (phase == LAST);

  // R3
  phase_wrap_chk: assert property (@(posedge osc_clk) disable iff (hold)
    (tick && phase == LAST) |=> phase == '0);

  // R12
  phase_hold_chk: assert property (@(posedge osc_clk) disable iff (!hold)
    hold |=> (phase == '0));
endmodule

// File: rtl/cpc_rst_qual.sv
module cpc_rst_qual #(
  parameter int MC_LEN     = 6,
  parameter int QUAL_MC    = 2,
  parameter int SETTLE_CYC = 16
) (
  input  logic osc_clk,
  input  logic rst_pin,
  input  logic tick,
  input  logic pd_exit,
  output logic core_rst
);
  localparam int QUAL = MC_LEN * QUAL_MC;
  localparam int CW   = $clog2(QUAL + 1);
  localparam int SW   = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] QUAL_V   = CW'(QUAL);
  localparam logic [SW-1:0] SETTLE_V = SW'(SETTLE_CYC);

  logic [CW-1:0] hi_cnt;
  logic [SW-1:0] settle_cnt;
  logic          settle_on;

  // Counts internal ticks with the pin high; any low sample starts over.
  always_ff @(posedge osc_clk) begin
    if (!rst_pin)                    hi_cnt <= '0;
    else if (tick && hi_cnt != QUAL_V) hi_cnt <= hi_cnt + 1'b1;
  end

  // Oscillator settle stretch, counted in raw oscillator cycles.
  always_ff @(posedge osc_clk) begin
    if (pd_exit)              settle_cnt <= SETTLE_V;
    else if (settle_cnt != '0) settle_cnt <= settle_cnt - 1'b1;
  end

  assign settle_on = (settle_cnt != '0);
  assign core_rst  = (hi_cnt == QUAL_V) | settle_on;

  // R4
  qual_src_chk: assert property (@(posedge osc_clk) disable iff (settle_on)
    core_rst |-> $past(rst_pin));
endmodule

// File: rtl/cpc_pwr_fsm.sv
module cpc_pwr_fsm
  import cpc_pkg::*;
#(
  parameter int N_IRQ = 2
) (
  input  logic             osc_clk,
  input  logic             rst_pin,
  input  logic             core_rst,
  input  logic             mc_end,
  input  logic             idle_req,
  input  logic             pdown_req,
  input  logic [N_IRQ-1:0] wake_irq,
  input  logic [N_IRQ-1:0] irq_en,
  output pmode_t           mode,
  output logic             pd_exit
);
  logic idle_pend;
  logic pd_pend;
  logic wake;

  assign wake    = |(wake_irq & irq_en);
  assign pd_exit = (mode == PM_PDOWN) & rst_pin;

  always_ff @(posedge osc_clk) begin
    if (mode == PM_PDOWN) begin
      if (rst_pin) mode <= PM_RUN;
      idle_pend <= 1'b0;
      pd_pend   <= 1'b0;
    end else if (core_rst) begin
      mode      <= PM_RUN;
      idle_pend <= 1'b0;
      pd_pend   <= 1'b0;
    end else begin
      unique case (mode)
        PM_RUN: begin
          if (mc_end) begin
            idle_pend <= 1'b0;
            pd_pend   <= 1'b0;
            if (pd_pend || pdown_req)      mode <= PM_PDOWN;
            else if (idle_pend || idle_req) mode <= PM_IDLE;
          end else begin
            idle_pend <= idle_pend | idle_req;
            pd_pend   <= pd_pend | pdown_req;
          end
        end
        PM_IDLE: begin
          if (wake) mode <= PM_RUN;
        end
        default: mode <= PM_RUN;
      endcase
    end
  end

  // R10
  pd_prio_chk: assert property (@(posedge osc_clk) disable iff (rst_pin)
    (mode == PM_RUN && !core_rst && mc_end && pdown_req && idle_req) |=> mode == PM_PDOWN);

  // R8
  idle_mask_chk: assert property (@(posedge osc_clk) disable iff (rst_pin)
    (mode == PM_IDLE && !core_rst && !wake) |=> mode == PM_IDLE);
endmodule

// File: rtl/clk_pwr_ctrl.sv
module clk_pwr_ctrl
  import cpc_pkg::*;
#(
  parameter int MC_LEN     = 6,
  parameter int QUAL_MC    = 2,
  parameter int SETTLE_CYC = 16,
  parameter int N_IRQ      = 2
) (
  input  logic                      osc_clk,
  input  logic                      rst_pin,
  input  logic                      x2_sel,
  input  logic                      idle_req,
  input  logic                      pdown_req,
  input  logic [N_IRQ-1:0]          wake_irq,
  input  logic [N_IRQ-1:0]          irq_en,
  output logic                      cpu_ce,
  output logic                      periph_ce,
  output logic [$clog2(MC_LEN)-1:0] mc_phase,
  output logic                      mc_strobe,
  output logic                      core_rst,
  output logic                      port_hi
);
  pmode_t mode;
  logic   tick;
  logic   run_en;
  logic   mc_end;
  logic   pd_exit;

  assign run_en = (mode != PM_PDOWN);

  cpc_prescaler u_presc (
    .osc_clk (osc_clk),
    .rst_pin (rst_pin),
    .x2_sel  (x2_sel),
    .run_en  (run_en),
    .tick    (tick)
  );

  cpc_mc_seq #(.MC_LEN(MC_LEN)) u_seq (
    .osc_clk (osc_clk),
    .tick    (tick),
    .hold    (core_rst),
    .phase   (mc_phase),
    .mc_end  (mc_end)
  );

  cpc_rst_qual #(
    .MC_LEN     (MC_LEN),
    .QUAL_MC    (QUAL_MC),
    .SETTLE_CYC (SETTLE_CYC)
  ) u_qual (
    .osc_clk  (osc_clk),
    .rst_pin  (rst_pin),
    .tick     (tick),
    .pd_exit  (pd_exit),
    .core_rst (core_rst)
  );

  cpc_pwr_fsm #(.N_IRQ(N_IRQ)) u_fsm (
    .osc_clk   (osc_clk),
    .rst_pin   (rst_pin),
    .core_rst  (core_rst),
    .mc_end    (mc_end),
    .idle_req  (idle_req),
    .pdown_req (pdown_req),
    .wake_irq  (wake_irq),
    .irq_en    (irq_en),
    .mode      (mode),
    .pd_exit   (pd_exit)
  );

  assign periph_ce = tick;
  assign cpu_ce    = tick & (mode == PM_RUN);
  assign mc_strobe = mc_end;
  assign port_hi   = rst_pin | core_rst;

  // R9
  pd_quiet_chk: assert property (@(posedge osc_clk) disable iff (rst_pin)
    (mode == PM_PDOWN) |-> (!periph_ce && !cpu_ce));
endmodule

// File: tb/clk_pwr_ctrl_tb.sv
module clk_pwr_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 16;
  localparam int QTICKS     = 12;

  localparam int S_CPU = 0, S_PER = 1, S_PHASE = 2, S_STB = 3, S_RST = 4, S_PORT = 5;

  logic       osc_clk = 1'b0;
  logic       rst_pin = 1'b0, x2_sel = 1'b0, idle_req = 1'b0, pdown_req = 1'b0;
  logic [1:0] wake_irq = 2'b00, irq_en = 2'b00;
  logic       cpu_ce, periph_ce, mc_strobe, core_rst, port_hi;
  logic [2:0] mc_phase;

  always #(CLK_PERIOD/2) osc_clk = ~osc_clk;

  clk_pwr_ctrl dut_i (
    .osc_clk(osc_clk), .rst_pin(rst_pin), .x2_sel(x2_sel),
    .idle_req(idle_req), .pdown_req(pdown_req),
    .wake_irq(wake_irq), .irq_en(irq_en),
    .cpu_ce(cpu_ce), .periph_ce(periph_ce), .mc_phase(mc_phase),
    .mc_strobe(mc_strobe), .core_rst(core_rst), .port_hi(port_hi)
  );

  typedef struct {
    string req;
    int    sel;
    int    exp;
  } item_t;

  item_t sbq[$];
  int    n_run  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;

  function automatic int probe(int sel);
    case (sel)
      S_CPU:   return int'(cpu_ce);
      S_PER:   return int'(periph_ce);
      S_PHASE: return int'(mc_phase);
      S_STB:   return int'(mc_strobe);
      S_RST:   return int'(core_rst);
      default: return int'(port_hi);
    endcase
  endfunction

  // Driver side: queue an expectation for the coming falling edge.
  task automatic expect_sig(string req, int sel, int exp);
    sbq.push_back('{req, sel, exp});
  endtask

  // Monitor: pops every queued item at the falling edge and compares.
  always @(negedge osc_clk) begin
    while (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      n_run++;
      if (probe(it.sel) != it.exp) begin
        n_fail++;
        $display("FAIL %s sel=%0d: actual %0d expected %0d", it.req, it.sel, probe(it.sel), it.exp);
      end
    end
  end

  task automatic check_val(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge osc_clk);
    #1;
  endtask

  task automatic qualify_reset();
    int ticks = 0;
    rst_pin = 1'b1;
    expect_sig("R5", S_PORT, 1);
    expect_sig("R4", S_RST, 0);
    while (ticks < QTICKS) begin
      logic t;
      t = periph_ce;
      step();
      if (t) ticks++;
      expect_sig("R4", S_RST, (ticks < QTICKS) ? 0 : 1);
    end
    repeat (3) begin
      step();
      expect_sig("R12", S_PHASE, 0);
      expect_sig("R4", S_RST, 1);
    end
    rst_pin = 1'b0;
    expect_sig("R4", S_RST, 1);
    step();
    expect_sig("R4", S_RST, 0);
    expect_sig("R12", S_PHASE, 0);
  endtask

  task automatic count_ticks(int cycles, output int cnt);
    cnt = 0;
    for (int i = 0; i < cycles; i++) begin
      if (periph_ce) cnt++;
      step();
    end
  endtask

  task automatic run_to_phase(int ph, string req);
    for (int i = 0; i < 12 && int'(mc_phase) != ph; i++) begin
      expect_sig(req, S_CPU, 1);
      step();
    end
  endtask

  initial begin
    int ph;
    int tk;
    int sb;
    repeat (4) step();

    // R4: a pulse shorter than two machine cycles is ignored
    rst_pin = 1'b1;
    expect_sig("R5", S_PORT, 1);
    repeat (6) begin
      step();
      expect_sig("R4", S_RST, 0);
    end
    rst_pin = 1'b0;
    repeat (2) step();

    qualify_reset();

    // R1 / R3: divided rate, phase walk and strobes
    ph = 0; tk = 0; sb = 0;
    for (int i = 0; i < 24; i++) begin
      logic pe;
      pe = periph_ce;
      if (mc_strobe) sb++;
      step();
      if (pe) begin
        tk++;
        ph = (ph == 5) ? 0 : ph + 1;
      end
      expect_sig("R3", S_PHASE, ph);
    end
    check_val("R1 ticks in 24 cycles", tk, 12);
    check_val("R3 strobes in 12 ticks", sb, 2);

    // R6: select change outside reset has no effect
    x2_sel = 1'b1;
    count_ticks(20, tk);
    check_val("R6 rate unchanged", tk, 10);

    qualify_reset();
    count_ticks(20, tk);
    check_val("R2 bypass rate", tk, 20);

    // R7: idle at the end of the machine cycle
    run_to_phase(2, "R7");
    idle_req = 1'b1;
    step();
    idle_req = 1'b0;
    run_to_phase(5, "R7");
    expect_sig("R7", S_CPU, 1);
    step();
    repeat (8) begin
      expect_sig("R7", S_CPU, 0);
      expect_sig("R7", S_PER, 1);
      step();
    end

    // R8: masked wake ignored, enabled wake resumes
    wake_irq = 2'b10;
    irq_en   = 2'b01;
    repeat (4) begin
      step();
      expect_sig("R8", S_CPU, 0);
    end
    irq_en = 2'b11;
    expect_sig("R8", S_CPU, 0);
    step();
    expect_sig("R8", S_CPU, 1);
    wake_irq = 2'b00;
    irq_en   = 2'b00;

    // R10 / R9: joint request, power-down wins and holds
    step();
    idle_req  = 1'b1;
    pdown_req = 1'b1;
    step();
    idle_req  = 1'b0;
    pdown_req = 1'b0;
    run_to_phase(5, "R10");
    step();
    wake_irq = 2'b11;
    irq_en   = 2'b11;
    repeat (20) begin
      expect_sig("R10", S_PER, 0);
      expect_sig("R9", S_CPU, 0);
      expect_sig("R9", S_RST, 0);
      step();
    end

    // R11: settle stretch after power-down exit
    rst_pin = 1'b1;
    expect_sig("R5", S_PORT, 1);
    expect_sig("R9", S_RST, 0);
    step();
    rst_pin  = 1'b0;
    wake_irq = 2'b00;
    irq_en   = 2'b00;
    expect_sig("R11", S_RST, 1);
    for (int k = 1; k <= SETTLE; k++) begin
      if (k == 3) idle_req = 1'b1;
      step();
      idle_req = 1'b0;
      if (k < SETTLE) begin
        expect_sig("R11", S_RST, 1);
        expect_sig("R12", S_PHASE, 0);
      end else begin
        expect_sig("R11", S_RST, 0);
      end
    end
    // R12: request made during reset was dropped
    repeat (14) begin
      expect_sig("R12", S_CPU, 1);
      step();
    end

    @(negedge osc_clk);
    #1;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge osc_clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule